// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block is a real-time clock and calendar that sits in the top eight byte locations of a 32K-by-8 memory map. It counts seconds, minutes, hours (00 to 23), day of week, date, month, year and century, all in packed BCD. A one-pulse-per-second tick advances the counters. The carry ripples from seconds up to the century byte. Month lengths and February in leap years are handled automatically.

The host reaches the clock through chip enable, output enable and write enable strobes, all active low, and an 8-bit data path. The interface is modelled synchronously: each clock cycle with the strobes active is one access. Every host access goes to a user-visible copy of the registers, never to the live counters. A read therefore never sees a carry that is only half done, and the counters keep running while the host holds the copy. Addresses below the window are reported to the surrounding storage through a select output. When the power-good input is low, the whole host interface is shut off.

Top module: `rtc_window`

## Requirements
- R1: An access with `ce_n` low and `pwr_ok` high is a register access when address bits [14:3] are all ones (0x7FF8 to 0x7FFF). Any other address raises `ram_sel` instead, and that access reads as zero and writes nothing here.
- R2: The register offset is taken from address bits [2:0]: 0 control, 1 year, 2 month, 3 date, 4 day of week, 5 hours, 6 minutes, 7 seconds. In the control byte, bit 7 is write-hold, bit 6 is read-hold, and bits [5:0] hold the century in BCD (00 to 39).
- R3: A register read (`ce_n`=0, `oe_n`=0, `we_n`=1) returns the user copy on `rdata` in the same cycle and raises `rdata_oe`. With `we_n` low the cycle is a write. Otherwise `rdata` is 0 and `rdata_oe` is 0.
- R4: On a tick, seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00, each carrying into the next field. 23:59:59 goes to 00:00:00.
- R5: A day carry sets the date to 01 and advances the month when the date has reached the month length (31, or 30 for months 04, 06, 09 and 11). The day of week steps 1 to 7 and then back to 1.
- R6: February has 29 days when the year is divisible by 4. For year 00 this also requires the century to be divisible by 4. In all other years February has 28 days.
- R7: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and increments the century, and century 39 wraps to 00.
- R8: With both hold bits clear, the user copy takes the counter values one cycle after each clock edge.
- R9: While read-hold is set, the user copy stays frozen and the counters keep advancing. Once it is cleared, the copy shows the current time again.
- R10: Time-field writes change the user copy only while write-hold is set. Writing the control byte with write-hold clear while it was set loads the counters from the copy, with the century taken from the written byte, in that cycle. A tick in the same cycle is dropped.
- R11: While `pwr_ok` is low, reads return 0, writes are ignored, `ram_sel` stays low, and ticks still advance the counters.
- R12: After reset the time is century 20, year 00, month 01, date 01, day 1, 00:00:00, and both hold bits are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse per second |
| pwr_ok | input | 1 | Supply in tolerance; low blocks the host |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not driven |
| rdata_oe | output | 1 | High while a register read drives `rdata` |
| ram_sel | output | 1 | Access targets storage below the window |

## Verification
Ticks are applied from times set just below each boundary: the end of the day, the ends of 30- and 31-day months, February 28 and 29 in common years, in leap years, in year 00 of a century divisible by four and in year 00 of one that is not, and the end of the year and of the century. These runs separate the month-length, leap and carry paths from one another. Hold patterns check that the counters and the user copy move apart: a read-hold with ticks under it, writes with write-hold clear, and a transfer that lands on a tick. Power-fail cycles and out-of-window addresses show the blocked and passed-through cases at the ports.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int NFIELD = 8;
   localparam int O_CTRL = 0;
   localparam int O_YEAR = 1;
   localparam int O_MON  = 2;
   localparam int O_DATE = 3;
   localparam int O_DOW  = 4;
   localparam int O_HOUR = 5;
   localparam int O_MIN  = 6;
   localparam int O_SEC  = 7;

   typedef logic [7:0] bcd8_t;
   typedef bcd8_t [NFIELD-1:0] bank_t;

   function automatic bcd8_t bcd_inc(input bcd8_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // Two-digit BCD value divisible by four
   function automatic logic bcd_div4(input bcd8_t v);
      if (v[4]) return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
      return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
   endfunction

   function automatic bcd8_t month_len(input bcd8_t mon, input logic leap);
      case (mon)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic bcd8_t field_hi(input int o);
      case (o)
         O_CTRL:  return 8'h39;
         O_YEAR:  return 8'h99;
         O_MON:   return 8'h12;
         O_DATE:  return 8'h31;
         O_DOW:   return 8'h07;
         O_HOUR:  return 8'h23;
         default: return 8'h59;
      endcase
   endfunction

   function automatic bcd8_t field_lo(input int o);
      return (o == O_MON || o == O_DATE || o == O_DOW) ? 8'h01 : 8'h00;
   endfunction

   function automatic bcd8_t field_rst(input int o);
      return (o == O_CTRL) ? 8'h20 : field_lo(o);
   endfunction

   // Carry order, least significant first
   function automatic int chain_off(input int k);
      case (k)
         0:       return O_SEC;
         1:       return O_MIN;
         2:       return O_HOUR;
         3:       return O_DATE;
         4:       return O_MON;
         5:       return O_YEAR;
         default: return O_CTRL;
      endcase
   endfunction

   function automatic bank_t rst_bank();
      bank_t b;
      for (int i = 0; i < NFIELD; i++) b[i] = field_rst(i);
      return b;
   endfunction
endpackage

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap
   import rtc_pkg::*;
#(
   parameter bcd8_t RST_VAL = 8'h00
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  en,
   input  logic  ld,
   input  bcd8_t ld_val,
   input  bcd8_t lo,
   input  bcd8_t hi,
   output bcd8_t q,
   output logic  wrap
);
   assign wrap = en && (q >= hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (ld) q <= ld_val;
      else if (en) q <= (q >= hi) ? lo : bcd_inc(q);
   end

   AST_WRAP_TO_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ld && q >= hi) |=> (q == $past(lo))); // R4
endmodule

// File: rtl/rtc_live_ctr.sv
module rtc_live_ctr
   import rtc_pkg::*;
#(
   parameter bit FULL_CENTURY_RULE = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tick,
   input  logic  ld,
   input  bank_t ld_val,
   output bank_t live
);
   localparam int NCHAIN = NFIELD - 1;

   logic [NCHAIN-1:0] en_c;
   logic [NCHAIN-1:0] wrap_c;
   logic              dow_wrap;
   logic              yr4;
   logic              leap;
   bcd8_t             hi_date;

   assign en_c[0] = tick;
   assign yr4     = bcd_div4(live[O_YEAR]);

   if (FULL_CENTURY_RULE) begin : g_full_rule
      assign leap = yr4 && ((live[O_YEAR] != 8'h00) || bcd_div4(live[O_CTRL]));
   end else begin : g_year_rule
      assign leap = yr4;
   end

   assign hi_date = month_len(live[O_MON], leap);

   for (genvar k = 0; k < NCHAIN; k++) begin : g_chain
      localparam int O = chain_off(k);
      bcd8_t hi_k;
      if (O == O_DATE) begin : g_dyn
         assign hi_k = hi_date;
      end else begin : g_fix
         assign hi_k = field_hi(O);
      end
      rtc_bcd_wrap #(.RST_VAL(field_rst(O))) u_field (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (en_c[k]),
         .ld     (ld),
         .ld_val (ld_val[O]),
         .lo     (field_lo(O)),
         .hi     (hi_k),
         .q      (live[O]),
         .wrap   (wrap_c[k])
      );
      if (k < NCHAIN - 1) begin : g_carry
         assign en_c[k+1] = wrap_c[k];
      end
   end

   // Day of week steps with every day carry
   rtc_bcd_wrap #(.RST_VAL(field_rst(O_DOW))) u_dow (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_c[3]),
      .ld     (ld),
      .ld_val (ld_val[O_DOW]),
      .lo     (field_lo(O_DOW)),
      .hi     (field_hi(O_DOW)),
      .q      (live[O_DOW]),
      .wrap   (dow_wrap)
   );

   AST_DOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (dow_wrap && !ld) |=> (live[O_DOW] == 8'h01)); // R5
   AST_CENTURY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_c[NCHAIN-1] && !ld) |=> (live[O_CTRL] == 8'h00)); // R7
   AST_FEB_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld && live[O_MON] == 8'h02 && live[O_DATE] == 8'h28 && !leap
       && live[O_HOUR] == 8'h23 && live[O_MIN] == 8'h59 && live[O_SEC] == 8'h59)
      |=> (live[O_DATE] == 8'h01)); // R6
endmodule

// File: rtl/rtc_user_regs.sv
module rtc_user_regs
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [2:0] off,
   input  bcd8_t      wdata,
   input  bank_t      live,
   output bank_t      ureg,
   output logic       wr_hold,
   output logic       rd_hold,
   output logic       ld
);
   localparam bank_t URST = rst_bank();

   // Release of write-hold pushes the copy into the counters
   assign ld = wr && (off == 3'(O_CTRL)) && wr_hold && !wdata[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ureg    <= URST;
         wr_hold <= 1'b0;
         rd_hold <= 1'b0;
      end else begin
         if (!rd_hold && !wr_hold) ureg <= live;
         if (wr) begin
            if (off == 3'(O_CTRL)) begin
               ureg[O_CTRL] <= {2'b00, wdata[5:0]};
               wr_hold      <= wdata[7];
               rd_hold      <= wdata[6];
            end else if (wr_hold) begin
               ureg[off] <= wdata;
            end
         end
      end
   end

   AST_COPY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_hold && !wr_hold && !wr) |=> (ureg == $past(live))); // R8
   AST_RDHOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hold && !wr) |=> $stable(ureg)); // R9
   AST_WRHOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hold && !wr) |=> $stable(ureg)); // R10
endmodule

// File: rtl/rtc_addr_dec.sv
module rtc_addr_dec #(
   parameter int ADDR_W = 15
) (
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              pwr_ok,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr,
   output logic              rd,
   output logic              ram_sel,
   output logic [2:0]        off
);
   logic acc;
   logic hit;

   assign acc     = !ce_n && pwr_ok;
   assign hit     = &addr[ADDR_W-1:3];
   assign off     = addr[2:0];
   assign wr      = acc && hit && !we_n;
   assign rd      = acc && hit && we_n && !oe_n;
   assign ram_sel = acc && !hit;
endmodule

// File: rtl/rtc_window.sv
module rtc_window
   import rtc_pkg::*;
#(
   parameter int ADDR_W            = 15,
   parameter int DATA_W            = 8,
   parameter bit FULL_CENTURY_RULE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              pwr_ok,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   output logic              ram_sel
);
   if (DATA_W != 8) begin : g_bad_data_w
      $error("rtc_window: DATA_W must be 8");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("rtc_window: ADDR_W must exceed the 3-bit register offset");
   end

   logic       wr;
   logic       rd;
   logic [2:0] off;
   logic       ld;
   logic       wr_hold;
   logic       rd_hold;
   bank_t      live;
   bank_t      ureg;
   bank_t      ld_val;

   rtc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .ce_n    (ce_n),
      .oe_n    (oe_n),
      .we_n    (we_n),
      .pwr_ok  (pwr_ok),
      .addr    (addr),
      .wr      (wr),
      .rd      (rd),
      .ram_sel (ram_sel),
      .off     (off)
   );

   rtc_user_regs u_user (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr),
      .off     (off),
      .wdata   (wdata),
      .live    (live),
      .ureg    (ureg),
      .wr_hold (wr_hold),
      .rd_hold (rd_hold),
      .ld      (ld)
   );

   always_comb begin
      ld_val         = ureg;
      ld_val[O_CTRL] = {2'b00, wdata[5:0]};
   end

   rtc_live_ctr #(.FULL_CENTURY_RULE(FULL_CENTURY_RULE)) u_live (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .ld     (ld),
      .ld_val (ld_val),
      .live   (live)
   );

   always_comb begin
      rdata = '0;
      if (rd) rdata = (off == 3'(O_CTRL)) ? {wr_hold, rd_hold, ureg[O_CTRL][5:0]} : ureg[off];
   end
   assign rdata_oe = rd;

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (live == $past(ld_val))); // R10
   AST_TICK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld) |=> (live[O_SEC] != $past(live[O_SEC]))); // R4
   AST_PWR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |-> (rdata == '0 && !rdata_oe && !ram_sel)); // R11
endmodule

// File: tb/rtc_window_bench.sv
module rtc_window_bench;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        pwr_ok = 1'b1;
   logic        ce_n = 1'b1;
   logic        oe_n = 1'b1;
   logic        we_n = 1'b1;
   logic [14:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        rdata_oe;
   logic        ram_sel;

   always #2.5 clk = ~clk;

   rtc_window u_rtc_window (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_ok(pwr_ok),
      .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .ram_sel(ram_sel)
   );

   int    checks = 0;
   int    fails = 0;
   int    cyc = 0;
   string req = "R12";

   // Behavioural model, indexed by register offset (0 holds the century)
   int L[8];
   int U[8];
   bit rdh, wrh;

   function automatic logic [7:0] b2(input int v);
      return 8'((v / 10) * 16 + (v % 10));
   endfunction
   function automatic int i2(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction
   function automatic int mdays(input int m, input int y, input int c);
      bit lp;
      lp = (y % 4 == 0) && (y != 0 || c % 4 == 0);
      if (m == 2) return lp ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic finish_up;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      bit acc, hit, wr, xfer;
      int off;
      int nL[8];
      int nU[8];
      if (!rst_n) begin
         L = '{20, 0, 1, 1, 1, 0, 0, 0};
         U = L;
         rdh = 1'b0;
         wrh = 1'b0;
      end else begin
         acc  = !ce_n && pwr_ok;
         hit  = (addr[14:3] == 12'hFFF);
         wr   = acc && hit && !we_n;
         off  = int'(addr[2:0]);
         xfer = wr && off == 0 && wrh && !wdata[7];
         nU = U;
         if (!rdh && !wrh) nU = L;
         if (wr) begin
            if (off == 0) begin
               nU[0] = i2({2'b00, wdata[5:0]});
               wrh = wdata[7];
               rdh = wdata[6];
            end else if (wrh) begin
               nU[off] = i2(wdata);
            end
         end
         nL = L;
         if (xfer) begin
            for (int i = 1; i < 8; i++) nL[i] = U[i];
            nL[0] = i2({2'b00, wdata[5:0]});
         end else if (tick) begin
            if (L[7] >= 59) begin
               nL[7] = 0;
               if (L[6] >= 59) begin
                  nL[6] = 0;
                  if (L[5] >= 23) begin
                     nL[5] = 0;
                     nL[4] = (L[4] >= 7) ? 1 : L[4] + 1;
                     if (L[3] >= mdays(L[2], L[1], L[0])) begin
                        nL[3] = 1;
                        if (L[2] >= 12) begin
                           nL[2] = 1;
                           if (L[1] >= 99) begin
                              nL[1] = 0;
                              nL[0] = (L[0] >= 39) ? 0 : L[0] + 1;
                           end else nL[1] = L[1] + 1;
                        end else nL[2] = L[2] + 1;
                     end else nL[3] = L[3] + 1;
                  end else nL[5] = L[5] + 1;
               end else nL[6] = L[6] + 1;
            end else nL[7] = L[7] + 1;
         end
         L = nL;
         U = nU;
      end
   end

   // Compare on every cycle, half a period after the edge
   always @(negedge clk) begin
      bit acc, hit, rd;
      logic [7:0] cb, exp;
      if (rst_n) begin
         acc = !ce_n && pwr_ok;
         hit = (addr[14:3] == 12'hFFF);
         rd  = acc && hit && we_n && !oe_n;
         cb  = b2(U[0]);
         exp = 8'h00;
         if (rd) exp = (addr[2:0] == 3'd0) ? {wrh, rdh, cb[5:0]} : b2(U[int'(addr[2:0])]);
         chk(rdata, exp, "rdata");
         chk({7'd0, rdata_oe}, {7'd0, rd}, "rdata_oe");
         chk({7'd0, ram_sel}, {7'd0, acc && !hit}, "ram_sel");
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
         finish_up();
      end
   end

   task automatic bus_idle(input int n);
      repeat (n) begin
         @(posedge clk); #1;
         ce_n = 1; oe_n = 1; we_n = 1; tick = 0;
      end
   endtask
   task automatic bus_wr(input int off, input logic [7:0] d);
      @(posedge clk); #1;
      ce_n = 0; we_n = 0; oe_n = 1; tick = 0;
      addr = {12'hFFF, 3'(off)}; wdata = d;
   endtask
   task automatic bus_rd(input int off);
      @(posedge clk); #1;
      ce_n = 0; we_n = 1; oe_n = 0; tick = 0;
      addr = {12'hFFF, 3'(off)};
   endtask
   task automatic read_all;
      for (int i = 0; i < 8; i++) bus_rd(i);
      bus_idle(1);
   endtask
   task automatic one_tick;
      @(posedge clk); #1;
      ce_n = 1; we_n = 1; oe_n = 1; tick = 1;
   endtask
   task automatic set_time(input int c, input int y, input int mo, input int d,
                           input int dw, input int h, input int mi, input int s);
      logic [7:0] cb;
      cb = b2(c);
      bus_wr(0, {2'b10, cb[5:0]});
      bus_wr(1, b2(y));  bus_wr(2, b2(mo)); bus_wr(3, b2(d));
      bus_wr(4, b2(dw)); bus_wr(5, b2(h));  bus_wr(6, b2(mi));
      bus_wr(7, b2(s));
      bus_wr(0, {2'b00, cb[5:0]});
      bus_idle(2);
   endtask
   task automatic edge_case(input int c, input int y, input int mo, input int d, input int dw);
      set_time(c, y, mo, d, dw, 23, 59, 59);
      one_tick();
      bus_idle(2);
      read_all();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      req = "R12"; bus_idle(2); read_all();
      req = "R8";  one_tick(); one_tick(); one_tick(); bus_idle(2); read_all();
      req = "R4";  set_time(20, 23, 6, 15, 3, 12, 59, 58);
      one_tick(); one_tick(); bus_idle(2); read_all();
      req = "R4";  edge_case(20, 23, 6, 15, 3);
      req = "R5";  edge_case(20, 23, 1, 31, 7);
      edge_case(20, 23, 4, 30, 2);
      edge_case(20, 23, 9, 30, 6);
      edge_case(20, 23, 11, 30, 5);
      edge_case(20, 23, 11, 29, 4);
      req = "R6";  edge_case(20, 23, 2, 28, 2);
      edge_case(20, 24, 2, 28, 3);
      edge_case(20, 24, 2, 29, 4);
      edge_case(20, 0, 2, 28, 1);
      edge_case(21, 0, 2, 28, 1);
      edge_case(20, 22, 2, 28, 1);
      req = "R7";  edge_case(20, 23, 12, 31, 7);
      edge_case(19, 99, 12, 31, 5);
      edge_case(39, 99, 12, 31, 5);
      // R9: read-hold freezes the copy while ticks continue
      req = "R9";  set_time(20, 30, 5, 10, 2, 8, 0, 0);
      bus_wr(0, 8'b0110_0000);
      one_tick(); one_tick(); one_tick(); bus_idle(1); read_all();
      req = "R2";  bus_rd(0); bus_idle(1);
      req = "R9";  bus_wr(0, 8'b0010_0000); bus_idle(2); read_all();
      // R10: writes without write-hold are ignored
      req = "R10"; bus_wr(7, 8'h42); bus_wr(5, 8'h11); bus_idle(2); read_all();
      // R10: transfer lands on a tick, the tick is lost
      bus_wr(0, 8'b1010_0000); bus_wr(7, 8'h30); bus_wr(6, 8'h15);
      @(posedge clk); #1;
      ce_n = 0; we_n = 0; oe_n = 1; tick = 1; addr = 15'h7FF8; wdata = 8'b0010_0001;
      bus_idle(2); read_all();
      // R3: strobe combinations
      req = "R3";
      @(posedge clk); #1; ce_n = 0; oe_n = 1; we_n = 1; addr = 15'h7FFF; tick = 0;
      @(posedge clk); #1; ce_n = 1; oe_n = 0; we_n = 1;
      @(posedge clk); #1; ce_n = 0; oe_n = 0; we_n = 0; wdata = 8'h05;
      bus_idle(1); read_all();
      // R11: power fail blocks access, counters keep going
      req = "R11";
      pwr_ok = 0;
      bus_wr(0, 8'b1100_0000); bus_rd(7); bus_rd(0);
      one_tick(); one_tick();
      @(posedge clk); #1; ce_n = 0; oe_n = 0; we_n = 1; addr = 15'h0123; tick = 0;
      bus_idle(1);
      pwr_ok = 1;
      bus_idle(2); read_all();
      // R1: addresses below the window go to storage
      req = "R1";
      @(posedge clk); #1; ce_n = 0; oe_n = 0; we_n = 1; addr = 15'h7FF7;
      @(posedge clk); #1; ce_n = 0; oe_n = 1; we_n = 0; addr = 15'h0007; wdata = 8'hFF;
      @(posedge clk); #1; ce_n = 0; oe_n = 0; we_n = 1; addr = 15'h3FFF;
      bus_idle(1); read_all();
      finish_up();
   end
endmodule